// File: doc/BRIEF.md
# Dual-Input Reference Select and Alarm Controller

This block is the control logic that decides which of two reference clock inputs feeds a downstream PLL, and that presents alarm and interrupt status on a small set of shared, tristatable pins. It receives per-input loss-of-signal and frequency-offset flags from separate detectors. It qualifies those flags into one alarm per input and then picks the active input. The choice comes from an external pin or a register bit in manual mode. In automatic mode the block picks on its own, based on the alarms.

In automatic mode the select pin turns into an indicator of the active input. If both inputs fail, the block keeps its last choice and asks the PLL to freeze. The first status pin can act as a maskable, polarity-programmable interrupt driven by sticky alarm-change flags, or as a plain alarm indicator for input 1. The second status pin can show the alarm for input 2. A read-only status word always holds the active input, both qualified alarms, the hold request and the sticky flags.

Top module: `refsel_ctrl`

## Requirements
- R1: In manual mode (`auto_mode`=0) with `sel_pin_en`=1, `sel_out` follows `sel_pin_in` one clock later: 0 selects input 1, 1 selects input 2.
- R2: In manual mode with `sel_pin_en`=0, `sel_out` follows `sel_reg` one clock later, and `sel_pin_in` has no effect.
- R3: The qualified alarm of input i is `los_in[i]` OR (`fos_en[i]` AND `fos_in[i]`). It appears one clock after the inputs in `status_reg[1]` (input 1) and `status_reg[2]` (input 2). A frequency-offset flag whose enable is 0 is ignored.
- R4: `act_pin_oe` is 1 only when `auto_mode`=1 and `act_pin_en`=1, and `act_pin_out` then equals the active input. `status_reg[0]` always equals `sel_out`, whatever the pin settings.
- R5: In automatic mode, when the active input is alarmed and the other is not, `sel_out` moves to the other input. This happens two clocks after the raw alarm input changes.
- R6: When both qualified alarms are present, `hold_req` is 1 and `status_reg[3]` is 1. In automatic mode the selection stays on the last active input.
- R7: After an automatic switch, no further automatic switch occurs for `MIN_DWELL` clocks (default 1).
- R8: A change of input i's qualified alarm sets sticky flag `status_reg[4+i]` one clock later, when `irq_mask[i]`=1. A 1 on `irq_clr[i]` clears that flag. With `irq_en`=1, status pin A shows the OR of the flags: active high when `irq_pol`=1 and active low when `irq_pol`=0.
- R9: With `irq_en`=0 and `alm1_pin_en`=1, status pin A drives input 1's alarm XOR `alm_pol`. With both `irq_en` and `alm1_pin_en` at 0, `stat_a_oe`=0.
- R10: With `alm2_pin_en`=1, status pin B drives input 2's alarm XOR `alm_pol`. Otherwise `stat_b_oe`=0.
- R11: While `rst_n`=0 (synchronous), `outs_en`, all pin output enables and `status_reg` are 0. `outs_en` becomes 1 one clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| los_in | input | 2 | Loss-of-signal flag per input |
| fos_in | input | 2 | Frequency-offset flag per input |
| fos_en | input | 2 | Include frequency offset in each input's alarm |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| sel_pin_en | input | 1 | Manual: 1 = select pin decides, 0 = register bit decides |
| sel_reg | input | 1 | Manual register choice |
| sel_pin_in | input | 1 | External select pin level |
| act_pin_en | input | 1 | Drive active-input indicator in automatic mode |
| irq_en | input | 1 | Status pin A acts as interrupt |
| irq_pol | input | 1 | Interrupt active level |
| alm1_pin_en | input | 1 | Status pin A shows input 1 alarm |
| alm2_pin_en | input | 1 | Status pin B shows input 2 alarm |
| alm_pol | input | 1 | Alarm pin polarity inversion |
| irq_mask | input | 2 | Per-input interrupt enable |
| irq_clr | input | 2 | Write-one-to-clear strobe per sticky flag |
| sel_out | output | 1 | Active input (0 = input 1, 1 = input 2) |
| hold_req | output | 1 | Frozen-state request to the PLL |
| act_pin_out | output | 1 | Active-input indicator pin value |
| act_pin_oe | output | 1 | Indicator pin output enable |
| stat_a_out | output | 1 | Status pin A value |
| stat_a_oe | output | 1 | Status pin A output enable |
| stat_b_out | output | 1 | Status pin B value |
| stat_b_oe | output | 1 | Status pin B output enable |
| outs_en | output | 1 | Clock outputs enabled (0 during reset) |
| status_reg | output | 6 | Read-only status {sticky[1:0], hold, alarm2, alarm1, active} |

## Verification
The assertions assume that the alarm flags and configuration bits are synchronous to `clk` and change only between edges. They also assume that `MIN_DWELL` is at least one wherever the dwell property is checked. The stimulus drives every input on the falling edge and holds it for whole cycles. It changes configuration only while the alarms are steady. It flips the alarms on consecutive cycles only in the dwell test, and that test is there to probe the anti-oscillation window.

// File: rtl/refsel_pkg.sv
// Shared constants and types for the reference select controller.
package refsel_pkg;
    localparam int NUM_IN = 2;

    // Read-only status word layout, most significant field first.
    typedef struct packed {
        logic [NUM_IN-1:0] sticky;
        logic              hold;
        logic              alm2;
        logic              alm1;
        logic              active;
    } stat_t;
endpackage

// File: rtl/alarm_qualify.sv
// Registers one qualified alarm per input: loss of signal, optionally ORed
// with frequency offset. Assumes the detector flags are synchronous to clk.
module alarm_qualify #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] los,
    input  logic [NUM-1:0] fos,
    input  logic [NUM-1:0] fos_use,
    output logic [NUM-1:0] alm_q
);
    for (genvar i = 0; i < NUM; i++) begin : g_in
        // Combine and register this input's alarm.
        always_ff @(posedge clk) begin
            if (!rst_n) alm_q[i] <= 1'b0;
            else        alm_q[i] <= los[i] | (fos_use[i] & fos[i]);
        end

        p_los_alarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
            los[i] |=> alm_q[i]);
    end
endmodule

// File: rtl/input_select.sv
// Chooses the active input: from the pin or the register bit in manual mode,
// or from the alarms in automatic mode with a minimum dwell after each switch.
// Assumes exactly two inputs; alm is already registered.
module input_select #(
    parameter int MIN_DWELL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       sel_pin_en,
    input  logic       sel_reg,
    input  logic       sel_pin_in,
    input  logic [1:0] alm,
    output logic       sel_q,
    output logic       hold_req
);
    localparam int DW = (MIN_DWELL < 1) ? 1 : $clog2(MIN_DWELL + 1);

    logic [DW-1:0] dwell_cnt;
    logic          man_pick;
    logic          auto_sw;

    // Manual source and automatic switch condition.
    always_comb begin
        man_pick = sel_pin_en ? sel_pin_in : sel_reg;
        auto_sw  = auto_mode && (dwell_cnt == '0) && alm[sel_q] && !alm[!sel_q];
        hold_req = &alm;
    end

    // Selection register and dwell counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            dwell_cnt <= '0;
        end else if (!auto_mode) begin
            sel_q     <= man_pick;
            dwell_cnt <= '0;
        end else if (auto_sw) begin
            sel_q     <= !sel_q;
            dwell_cnt <= DW'(MIN_DWELL);
        end else if (dwell_cnt != '0) begin
            dwell_cnt <= dwell_cnt - DW'(1);
        end
    end

    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && (&alm)) |=> $stable(sel_q));

    p_no_move_to_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && alm[!sel_q]) |=> $stable(sel_q));

    if (MIN_DWELL > 0) begin : g_dwell_chk
        p_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
            auto_sw |=> !auto_sw);
    end
endmodule

// File: rtl/irq_sticky.sv
// Sticky alarm-change flags: a masked change of a qualified alarm sets a
// flag; a write-one-to-clear strobe clears it, a same-cycle event wins.
module irq_sticky #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] alm,
    input  logic [NUM-1:0] mask,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] flags
);
    logic [NUM-1:0] alm_prev;
    logic [NUM-1:0] set_ev;

    // Masked change events.
    always_comb set_ev = (alm ^ alm_prev) & mask;

    // Previous alarm copy and flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_prev <= '0;
            flags    <= '0;
        end else begin
            alm_prev <= alm;
            flags    <= (flags & ~clr) | set_ev;
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set_ev)) |=> ((flags & $past(clr & ~set_ev)) == '0));
endmodule

// File: rtl/refsel_ctrl.sv
// Top of the reference select and alarm controller: qualifies alarms, picks
// the active input, keeps sticky interrupt flags and drives the shared,
// tristatable status pins. Configuration bits are plain static inputs.
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int MIN_DWELL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] los_in,
    input  logic [NUM_IN-1:0] fos_in,
    input  logic [NUM_IN-1:0] fos_en,
    input  logic              auto_mode,
    input  logic              sel_pin_en,
    input  logic              sel_reg,
    input  logic              sel_pin_in,
    input  logic              act_pin_en,
    input  logic              irq_en,
    input  logic              irq_pol,
    input  logic              alm1_pin_en,
    input  logic              alm2_pin_en,
    input  logic              alm_pol,
    input  logic [NUM_IN-1:0] irq_mask,
    input  logic [NUM_IN-1:0] irq_clr,
    output logic              sel_out,
    output logic              hold_req,
    output logic              act_pin_out,
    output logic              act_pin_oe,
    output logic              stat_a_out,
    output logic              stat_a_oe,
    output logic              stat_b_out,
    output logic              stat_b_oe,
    output logic              outs_en,
    output logic [$bits(stat_t)-1:0] status_reg
);
    logic [NUM_IN-1:0] alm_q;
    logic [NUM_IN-1:0] flags;
    logic              live_q;
    logic              irq_any;
    stat_t             st;

    alarm_qualify #(.NUM(NUM_IN)) u_qual (
        .clk(clk), .rst_n(rst_n), .los(los_in), .fos(fos_in),
        .fos_use(fos_en), .alm_q(alm_q)
    );

    input_select #(.MIN_DWELL(MIN_DWELL)) u_sel (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
        .sel_pin_en(sel_pin_en), .sel_reg(sel_reg), .sel_pin_in(sel_pin_in),
        .alm(alm_q), .sel_q(sel_out), .hold_req(hold_req)
    );

    irq_sticky #(.NUM(NUM_IN)) u_irq (
        .clk(clk), .rst_n(rst_n), .alm(alm_q), .mask(irq_mask),
        .clr(irq_clr), .flags(flags)
    );

    // Outputs-live flag: low while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Active indicator pin and clock-output enable.
    always_comb begin
        outs_en     = live_q;
        act_pin_out = sel_out;
        act_pin_oe  = live_q && auto_mode && act_pin_en;
    end

    // Status pin A: interrupt, input-1 alarm, or tristate.
    always_comb begin
        irq_any = |flags;
        if (irq_en) begin
            stat_a_out = irq_pol ? irq_any : !irq_any;
            stat_a_oe  = live_q;
        end else if (alm1_pin_en) begin
            stat_a_out = alm_q[0] ^ alm_pol;
            stat_a_oe  = live_q;
        end else begin
            stat_a_out = 1'b0;
            stat_a_oe  = 1'b0;
        end
    end

    // Status pin B: input-2 alarm or tristate.
    always_comb begin
        stat_b_out = alm2_pin_en ? (alm_q[1] ^ alm_pol) : 1'b0;
        stat_b_oe  = live_q && alm2_pin_en;
    end

    // Read-only status word.
    always_comb begin
        st.sticky  = flags;
        st.hold    = hold_req;
        st.alm2    = alm_q[1];
        st.alm1    = alm_q[0];
        st.active  = sel_out;
        status_reg = st;
    end

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!outs_en && !act_pin_oe && !stat_a_oe && !stat_b_oe));

    p_status_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_reg[0] == sel_out);
endmodule

// File: tb/refsel_ctrl_bench.sv
module refsel_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] los_in = '0, fos_in = '0, fos_en = '0, irq_mask = '0, irq_clr = '0;
    logic       auto_mode = 0, sel_pin_en = 0, sel_reg = 0, sel_pin_in = 0;
    logic       act_pin_en = 0, irq_en = 0, irq_pol = 0, alm1_pin_en = 0;
    logic       alm2_pin_en = 0, alm_pol = 0;
    logic       sel_out, hold_req, act_pin_out, act_pin_oe;
    logic       stat_a_out, stat_a_oe, stat_b_out, stat_b_oe, outs_en;
    logic [5:0] status_reg;

    always #10 clk = ~clk;

    refsel_ctrl u_refsel_ctrl (
        .clk(clk), .rst_n(rst_n), .los_in(los_in), .fos_in(fos_in),
        .fos_en(fos_en), .auto_mode(auto_mode), .sel_pin_en(sel_pin_en),
        .sel_reg(sel_reg), .sel_pin_in(sel_pin_in), .act_pin_en(act_pin_en),
        .irq_en(irq_en), .irq_pol(irq_pol), .alm1_pin_en(alm1_pin_en),
        .alm2_pin_en(alm2_pin_en), .alm_pol(alm_pol), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .sel_out(sel_out), .hold_req(hold_req),
        .act_pin_out(act_pin_out), .act_pin_oe(act_pin_oe),
        .stat_a_out(stat_a_out), .stat_a_oe(stat_a_oe),
        .stat_b_out(stat_b_out), .stat_b_oe(stat_b_oe),
        .outs_en(outs_en), .status_reg(status_reg)
    );

    localparam int S_SEL = 0, S_HOLD = 1, S_ACT = 2, S_ACT_OE = 3, S_A = 4,
                   S_A_OE = 5, S_B = 6, S_B_OE = 7, S_EN = 8, S_STAT = 9;

    typedef struct {
        string      req;
        int         sig;
        logic [7:0] exp;
    } item_t;

    item_t queue_q[$];
    event  chk_ev;
    int    n_total = 0;
    int    n_fail = 0;
    bit    done = 0;

    function automatic logic [7:0] observe(int s);
        case (s)
            S_SEL:    return {7'd0, sel_out};
            S_HOLD:   return {7'd0, hold_req};
            S_ACT:    return {7'd0, act_pin_out};
            S_ACT_OE: return {7'd0, act_pin_oe};
            S_A:      return {7'd0, stat_a_out};
            S_A_OE:   return {7'd0, stat_a_oe};
            S_B:      return {7'd0, stat_b_out};
            S_B_OE:   return {7'd0, stat_b_oe};
            S_EN:     return {7'd0, outs_en};
            default:  return {2'd0, status_reg};
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = queue_q.pop_front();
                act = observe(it.sig);
                n_total++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sig%0d actual=%0h expected=%0h", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int sig, logic [7:0] exp);
        queue_q.push_back('{req, sig, exp});
        -> chk_ev;
        #1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R11: reset with every enable asserted.
        auto_mode = 1; act_pin_en = 1; irq_en = 1; alm2_pin_en = 1; los_in = 2'b11;
        step(3);
        check("R11", S_EN, 0);
        check("R11", S_ACT_OE, 0);
        check("R11", S_A_OE, 0);
        check("R11", S_B_OE, 0);
        check("R11", S_STAT, 0);
        auto_mode = 0; act_pin_en = 0; irq_en = 0; alm2_pin_en = 0; los_in = 0;
        rst_n = 1;
        step(1);
        check("R11", S_EN, 1);
        check("R11", S_SEL, 0);

        // R2: register select, pin ignored.
        sel_reg = 1; sel_pin_in = 0; act_pin_en = 1;
        step(1);
        check("R2", S_SEL, 1);
        check("R4", S_ACT_OE, 0);
        check("R4", S_STAT, 6'b000001);

        // R1: pin select.
        sel_pin_en = 1;
        step(1);
        check("R1", S_SEL, 0);
        sel_pin_in = 1;
        step(1);
        check("R1", S_SEL, 1);

        // R4/R5: automatic mode.
        auto_mode = 1;
        step(1);
        check("R4", S_ACT, 1);
        check("R4", S_ACT_OE, 1);
        los_in[1] = 1;
        step(1);
        check("R5", S_SEL, 1);
        check("R3", S_STAT, 6'b000101);
        step(1);
        check("R5", S_SEL, 0);
        check("R4", S_ACT, 0);
        act_pin_en = 0;
        step(1);
        check("R4", S_ACT_OE, 0);
        check("R4", S_STAT, 6'b000100);

        // R3/R6: frequency offset qualification and hold.
        fos_in[0] = 1;
        step(3);
        check("R3", S_SEL, 0);
        check("R3", S_HOLD, 0);
        fos_en[0] = 1;
        step(1);
        check("R6", S_HOLD, 1);
        check("R6", S_STAT, 6'b001110);
        step(2);
        check("R6", S_SEL, 0);
        los_in[1] = 0;
        step(2);
        check("R5", S_SEL, 1);
        check("R6", S_HOLD, 0);
        check("R3", S_STAT, 6'b000011);

        // R7: dwell blocks an immediate switch back.
        fos_in[0] = 0; los_in[1] = 1;
        step(1);
        fos_in[0] = 1; los_in[1] = 0;
        step(1);
        check("R7", S_SEL, 0);
        step(1);
        check("R7", S_SEL, 0);
        step(1);
        check("R7", S_SEL, 1);

        // R9/R10: alarm pins and polarity.
        alm1_pin_en = 1; alm_pol = 0;
        step(1);
        check("R9", S_A, 1);
        check("R9", S_A_OE, 1);
        alm_pol = 1;
        step(1);
        check("R9", S_A, 0);
        alm2_pin_en = 1;
        step(1);
        check("R10", S_B, 1);
        check("R10", S_B_OE, 1);
        alm2_pin_en = 0;
        step(1);
        check("R10", S_B_OE, 0);
        alm1_pin_en = 0;
        step(1);
        check("R9", S_A_OE, 0);

        // R8: sticky interrupt, polarity, mask and clear.
        irq_en = 1; irq_pol = 1; irq_mask = 2'b10;
        step(1);
        check("R8", S_A, 0);
        check("R8", S_A_OE, 1);
        los_in[1] = 1;
        step(2);
        check("R8", S_A, 1);
        check("R8", S_STAT, 6'b101111);
        irq_pol = 0;
        step(1);
        check("R8", S_A, 0);
        irq_pol = 1;
        fos_in[0] = 0;
        step(2);
        check("R8", S_STAT, 6'b100100);
        irq_clr = 2'b10;
        step(1);
        irq_clr = 2'b00;
        step(1);
        check("R8", S_A, 0);
        check("R8", S_STAT, 6'b000100);

        step(1);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule